// File: doc/BRIEF.md
# Iterative Integer Square Root Engine

This block finds the integer square root of an unsigned 8-bit value in several clock cycles. A small Moore controller drives a registered datapath. The datapath keeps a running perfect square and the next odd increment. The square begins at 1 and the increment at 3. On each update step the increment is added to the square, and the increment then grows by two. The loop runs while the square does not exceed the stored operand. When it ends, the root is half of the increment, minus one.

The user presents the operand and raises `go` while the engine is idle. The controller then alternates between compare and update cycles. When the loop ends it parks in its final state, loads the result register and raises `done`. The result and `done` stay put until the synchronous active-high clear returns the engine to idle. While the engine is idle it copies the operand every cycle and reloads the square and increment registers with their starting values. A new run therefore always begins from a clean state.

Top module: `isqrt_odd`

## Requirements
- R1: With `clr` high at a rising edge, the engine returns to idle, and from the next cycle on `root` reads 0 and `done` reads 0. This also holds when a result is already being shown.
- R2: After a run, `root` equals the floor of the square root of the operand, for every operand value from 0 to 255.
- R3: A run for an operand whose root is r raises `done` exactly 2r+2 rising edges after the edge at which idle sampled `go` high. `root` is valid in that same cycle.
- R4: The operand is taken from `radicand` at the edge where idle sees `go` high. Changes to `radicand` after that edge have no effect on the result.
- R5: While idle with `go` low, the engine waits without limit, and `done` stays 0.
- R6: Once `done` is 1, it stays 1 and `root` stays unchanged until clear, whatever `go` and `radicand` do.
- R7: A clear in the middle of a run abandons that run. A run started after the clear produces the correct root for its own operand.
- R8: Boundary operands give exact results: 0 gives 0, 1 gives 1, 255 gives 15, and perfect squares such as 144 give their exact root (12).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous active-high clear of controller and datapath |
| go | input | 1 | Start request, sampled while idle |
| radicand | input | 8 | Unsigned operand, captured at the start edge |
| root | output | 4 | Registered integer square root |
| done | output | 1 | Registered flag, high while the result is valid |

## Verification
A corrupted square or increment register shows at the ports in one of two ways. Either `root` is off from the floor square root, or `done` arrives earlier or later than 2r+2 edges after the start. The bench checks both for every operand, so a wrong internal value shows up within a single run of at most 34 cycles. A controller that leaves its final state, or a result register that reloads after the result is shown, breaks the held value of `root` or `done` within one cycle. The bench holds the engine in that state and toggles the inputs to expose it.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TEST = 2'b01,
    ST_STEP = 2'b10,
    ST_FIN  = 2'b11
  } isqrt_state_t;
endpackage

// File: rtl/isqrt_ldreg.sv
module isqrt_ldreg #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)
      q <= INIT;
    else if (ld)
      q <= d;
  end
endmodule

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
  import isqrt_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic go,
  input  logic le_flag,
  output logic ld_rad,
  output logic ld_step,
  output logic ld_out
);
  isqrt_state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (clr)
      st <= ST_IDLE;
    else
      st <= st_nx;
  end

  // next-state logic
  always_comb begin
    case (st)
      ST_IDLE: st_nx = go ? ST_TEST : ST_IDLE;
      ST_TEST: st_nx = le_flag ? ST_STEP : ST_FIN;
      ST_STEP: st_nx = ST_TEST;
      ST_FIN:  st_nx = ST_FIN;
      default: st_nx = ST_IDLE;
    endcase
  end

  // Moore outputs, a function of state only
  always_comb begin
    ld_rad  = 1'b0;
    ld_step = 1'b0;
    ld_out  = 1'b0;
    case (st)
      ST_IDLE: ld_rad  = 1'b1;
      ST_TEST: ;
      ST_STEP: ld_step = 1'b1;
      ST_FIN:  ld_out  = 1'b1;
      default: ;
    endcase
  end

  // R5: idle waits for go
  a_r5_idle_wait: assert property (@(posedge clk) disable iff (clr)
    (st == ST_IDLE && !go) |=> (st == ST_IDLE));

  // R3: every update step is followed by a compare
  a_r3_step_returns: assert property (@(posedge clk) disable iff (clr)
    (st == ST_STEP) |=> (st == ST_TEST));

  // R6: final state is left only by clear
  a_r6_final_sticky: assert property (@(posedge clk) disable iff (clr)
    (st == ST_FIN) |=> (st == ST_FIN));
endmodule

// File: rtl/isqrt_dpath.sv
module isqrt_dpath #(
  parameter int RAD_W = 8,
  localparam int ROOT_W  = RAD_W / 2,
  localparam int DELTA_W = ROOT_W + 1,
  localparam int SQ_W    = RAD_W + 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              ld_rad,
  input  logic              ld_step,
  input  logic              ld_out,
  input  logic [RAD_W-1:0]  radicand,
  output logic              le_flag,
  output logic [ROOT_W-1:0] root
);
  localparam logic [SQ_W-1:0]    SQ_INIT = SQ_W'(1);
  localparam logic [DELTA_W-1:0] DL_INIT = DELTA_W'(3);

  logic [RAD_W-1:0]   rad_q;
  logic [SQ_W-1:0]    sq_q, sq_d;
  logic [DELTA_W-1:0] dl_q, dl_d;
  logic [ROOT_W-1:0]  root_d;
  logic               sd_ld;

  // idle reloads the starting values, update loads the sums
  assign sd_ld  = ld_rad | ld_step;
  assign sq_d   = ld_rad ? SQ_INIT : (sq_q + SQ_W'(dl_q));
  assign dl_d   = ld_rad ? DL_INIT : (dl_q + DELTA_W'(2));
  assign le_flag = (sq_q <= {1'b0, rad_q});
  // increment wraps modulo 2^DELTA_W on the last step; the halving
  // and subtraction wrap the same way, so the root stays exact
  assign root_d = dl_q[DELTA_W-1:1] - ROOT_W'(1);

  isqrt_ldreg #(.W(RAD_W), .INIT('0)) u_rad (
    .clk(clk), .clr(clr), .ld(ld_rad), .d(radicand), .q(rad_q));

  isqrt_ldreg #(.W(SQ_W), .INIT(SQ_INIT)) u_sq (
    .clk(clk), .clr(clr), .ld(sd_ld), .d(sq_d), .q(sq_q));

  isqrt_ldreg #(.W(DELTA_W), .INIT(DL_INIT)) u_dl (
    .clk(clk), .clr(clr), .ld(sd_ld), .d(dl_d), .q(dl_q));

  isqrt_ldreg #(.W(ROOT_W), .INIT('0)) u_res (
    .clk(clk), .clr(clr), .ld(ld_out), .d(root_d), .q(root));

  // R2: the increment is always odd
  a_r2_delta_odd: assert property (@(posedge clk) disable iff (clr)
    dl_q[0]);

  // R2: the running square never becomes zero
  a_r2_square_nonzero: assert property (@(posedge clk) disable iff (clr)
    (sq_q != '0));
endmodule

// File: rtl/isqrt_odd.sv
module isqrt_odd #(
  parameter int RAD_W = 8,
  localparam int ROOT_W = RAD_W / 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              go,
  input  logic [RAD_W-1:0]  radicand,
  output logic [ROOT_W-1:0] root,
  output logic              done
);
  logic le_flag, ld_rad, ld_step, ld_out;

  isqrt_ctrl u_ctrl (
    .clk(clk), .clr(clr), .go(go), .le_flag(le_flag),
    .ld_rad(ld_rad), .ld_step(ld_step), .ld_out(ld_out));

  isqrt_dpath #(.RAD_W(RAD_W)) u_dp (
    .clk(clk), .clr(clr), .ld_rad(ld_rad), .ld_step(ld_step),
    .ld_out(ld_out), .radicand(radicand), .le_flag(le_flag), .root(root));

  always_ff @(posedge clk) begin
    if (clr)
      done <= 1'b0;
    else if (ld_out)
      done <= 1'b1;
  end

  // R2: an update step is taken only when the square is within range
  a_r2_step_when_le: assert property (@(posedge clk) disable iff (clr)
    ld_step |-> le_flag);

  // R6: result and flag hold once shown
  a_r6_result_held: assert property (@(posedge clk) disable iff (clr)
    done |=> (done && $stable(root)));
endmodule

// File: tb/sim_isqrt_odd.sv
`timescale 1ns/1ps
module sim_isqrt_odd;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       go = 1'b0;
  logic [7:0] radicand = 8'd0;
  logic [3:0] root;
  logic       done;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  isqrt_odd u0 (.clk(clk), .clr(clr), .go(go), .radicand(radicand),
                .root(root), .done(done));

  // {operand, expected root}
  localparam logic [11:0] VEC [0:11] = '{
    12'h000, 12'h011, 12'h021, 12'h031, 12'h042, 12'h0F3,
    12'h104, 12'h639, 12'h64A, 12'h8FB, 12'h90C, 12'hFFF };

  function automatic int ref_root(input int a);
    int r = 0;
    while ((r + 1) * (r + 1) <= a) r++;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
  endtask

  // start a run from idle and count edges until done
  task automatic run(input logic [7:0] a, output int lat);
    @(negedge clk); radicand = a; go = 1'b1;
    @(posedge clk);
    @(negedge clk); go = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    // R1: reset state
    @(posedge clk); @(posedge clk);
    @(negedge clk); clr = 1'b0;
    chk(root == 4'd0, "R1 root after clear", int'(root), 0);
    chk(done == 1'b0, "R1 done after clear", int'(done), 0);

    // R5: idle with go low never finishes
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R5 idle wait", int'(done), 0);

    // R2, R3, R8: table walk
    foreach (VEC[i]) begin
      do_clear();
      run(VEC[i][11:4], lat);
      chk(root == VEC[i][3:0], "R8 table root", int'(root), int'(VEC[i][3:0]));
      chk(lat == 2 * int'(VEC[i][3:0]) + 2, "R3 latency", lat, 2 * int'(VEC[i][3:0]) + 2);
    end

    // R1: clear while a result is shown (last entry was 255)
    do_clear();
    chk(root == 4'd0 && done == 1'b0, "R1 clear over result",
        int'({done, root}), 0);

    // R2: exhaustive sweep
    for (int a = 0; a < 256; a++) begin
      do_clear();
      run(8'(a), lat);
      chk(root == 4'(ref_root(a)), "R2 sweep root", int'(root), ref_root(a));
    end

    // R4: operand changes before and after the start edge
    do_clear();
    @(negedge clk); radicand = 8'd200;
    @(negedge clk); radicand = 8'd16; go = 1'b1;
    @(posedge clk);
    @(negedge clk); go = 1'b0; radicand = 8'd255;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    chk(root == 4'd4, "R4 operand captured at start", int'(root), 4);

    // R6: result held against input activity
    @(negedge clk); go = 1'b1; radicand = 8'd9;
    repeat (10) @(posedge clk);
    @(negedge clk); go = 1'b0;
    chk(root == 4'd4, "R6 root held", int'(root), 4);
    chk(done == 1'b1, "R6 done held", int'(done), 1);

    // R7: clear mid-run, then a fresh run
    do_clear();
    @(negedge clk); radicand = 8'd255; go = 1'b1;
    @(posedge clk);
    @(negedge clk); go = 1'b0;
    repeat (7) @(posedge clk);
    @(negedge clk); clr = 1'b1;
    @(posedge clk);
    @(negedge clk); clr = 1'b0;
    chk(root == 4'd0 && done == 1'b0, "R7 abandoned run", int'({done, root}), 0);
    run(8'd144, lat);
    chk(root == 4'd12, "R7 run after abort", int'(root), 12);
    chk(lat == 26, "R7 latency after abort", lat, 26);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule